// File: doc/BRIEF.md
# Range TLB Invalidation Sequencer

This block takes one request to invalidate a span of virtual addresses and turns it into a series of single-entry flush writes toward a set-associative translation cache. A small page can sit in only one set, and larger mappings can sit in many. Covering a range therefore means walking one flush per 4 KB page, up to the number of sets in the cache. Beyond that count every set has already been visited, so further flushes add nothing.

The walk is only needed on one hardware generation. The block reads the major-version nibble of the version word. When that nibble equals the multi-flush revision, the flush count is derived from the byte size. On any other revision a single flush is sent. Upstream, the block uses a request/busy/done handshake. Downstream, it offers at most one flush word per cycle, and the receiver can stall it with a ready signal.

Top module: `rinv_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy`, `done` and `flush_valid` are low.
- R2: If `hw_version[31:28]` differs from 2, an accepted request produces exactly one flush write, whatever its size.
- R3: If `hw_version[31:28]` equals 2, the number of flush writes is `req_size` divided by 4096 (integer division). For example, 4096 bytes gives 1 and 65536 bytes gives 16.
- R4: On revision 2 the flush count never exceeds 64. A 1 MB request gives 64 and a 2 MB request also gives 64.
- R5: On revision 2, a size below 4096 bytes still produces exactly one flush write.
- R6: Each flush word equals the page address with bits [11:0] cleared and bit 0 set to 1.
- R7: Every flush word after the first is 4096 greater than the previous one, starting from the 4 KB-aligned request address.
- R8: A request is accepted when `req_valid` is high and `busy` is low. `busy` and `flush_valid` are high from the cycle after acceptance until the cycle of the last flush handshake. In the cycle after that handshake, `busy` is low and `done` is high for exactly one cycle.
- R9: A `req_valid` raised while `busy` is high is ignored. The running series keeps its addresses and its count, and no second series follows.
- R10: A flush write completes only when `flush_valid` and `flush_ready` are both high. While `flush_ready` is low, `flush_data` holds its value and the count does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Range invalidation request |
| req_addr | input | 32 | Start virtual address of the range |
| req_size | input | 32 | Range size in bytes |
| hw_version | input | 32 | Hardware version word; bits [31:28] hold the major revision |
| busy | output | 1 | Series in progress |
| done | output | 1 | One-cycle pulse after the last flush write |
| flush_valid | output | 1 | Flush word available |
| flush_ready | input | 1 | Downstream accepts the flush word |
| flush_data | output | 32 | Page-aligned address with bit 0 set |

## Verification
A wrong remaining count shows up as a `done` pulse one or more handshakes too early or too late. The bench counts handshakes for every size class, so the error is caught at the end of the series. A wrong page register shows up in the very first or second flush word, because every accepted word is compared with its expected address as it is taken. A stall that leaks a step shows up as a skipped address at the next handshake after ready returns. A request leaking in while busy shows up as a changed address, or as `busy` rising again after `done`.

// File: rtl/rinv_pkg.sv
package rinv_pkg;

    // Position of the major-revision nibble in the version word
    localparam int VER_MSB = 31;
    localparam int VER_LSB = 28;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Number of flushes implied by a byte size, clamped to [1, max_n]
    function automatic int unsigned page_count(input logic [31:0] size_b,
                                               input int unsigned shift,
                                               input int unsigned max_n);
        logic [31:0] pages;
        pages = size_b >> shift;
        if (pages == 32'd0)
            return 1;
        else if (pages >= max_n)
            return max_n;
        else
            return int'(pages);
    endfunction

endpackage

// File: rtl/rinv_count_calc.sv
module rinv_count_calc
    import rinv_pkg::*;
#(
    parameter int SIZE_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int MAX_INV     = 64,
    parameter int CNT_W       = 7,
    parameter int MULTI_MAJOR = 2
) (
    input  logic [SIZE_W-1:0] req_size,
    input  logic [31:0]       hw_version,
    output logic [CNT_W-1:0]  inv_count
);

    logic [VER_MSB-VER_LSB:0] major;
    assign major = hw_version[VER_MSB:VER_LSB];

    always_comb begin
        if (major == (VER_MSB-VER_LSB+1)'(MULTI_MAJOR))
            inv_count = CNT_W'(page_count(32'(req_size), PAGE_SHIFT, MAX_INV));
        else
            inv_count = CNT_W'(1);
    end

    always_comb begin
        a_r4_count_cap: assert (inv_count >= CNT_W'(1) && inv_count <= CNT_W'(MAX_INV));
    end

endmodule

// File: rtl/rinv_addr_step.sv
module rinv_addr_step #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [ADDR_W-1:0] flush_data
);

    localparam int PFN_W = ADDR_W - PAGE_SHIFT;

    logic [PFN_W-1:0] cur_pfn;

    always_ff @(posedge clk) begin
        if (rst)
            cur_pfn <= '0;
        else if (load)
            cur_pfn <= load_addr[ADDR_W-1:PAGE_SHIFT];
        else if (step)
            cur_pfn <= cur_pfn + PFN_W'(1);
    end

    assign flush_data = {cur_pfn, {(PAGE_SHIFT-1){1'b0}}, 1'b1};

    // R7: a step (without reload) moves exactly one page forward
    a_r7_page_step: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (flush_data == $past(flush_data) + ADDR_W'(1 << PAGE_SHIFT)));

    // R10: no step and no load leaves the word untouched
    a_r10_hold_word: assert property (@(posedge clk) disable iff (rst)
        (!step && !load) |=> $stable(flush_data));

endmodule

// File: rtl/rinv_ctrl.sv
module rinv_ctrl
    import rinv_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             flush_ready,
    output logic             busy,
    output logic             done,
    output logic             flush_valid,
    output logic             load,
    output logic             step
);

    seq_state_e       state;
    logic [CNT_W-1:0] remaining;

    assign busy        = (state == ST_RUN);
    assign done        = (state == ST_DONE);
    assign flush_valid = busy;
    assign load        = req_valid && !busy;
    assign step        = busy && flush_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remaining <= '0;
        end else if (load) begin
            state     <= ST_RUN;
            remaining <= load_cnt;
        end else if (step) begin
            if (remaining == CNT_W'(1))
                state <= ST_DONE;
            remaining <= remaining - CNT_W'(1);
        end else if (state == ST_DONE) begin
            state <= ST_IDLE;
        end
    end

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: done only follows a final handshake
    a_r8_done_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(step));

    // R10, R9: a stalled run keeps its count even with a new request present
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !flush_ready) |=> (busy && $stable(remaining)));

    // R8: a running series never has zero left
    a_r8_nonzero_run: assert property (@(posedge clk) disable iff (rst)
        busy |-> (remaining != '0));

endmodule

// File: rtl/rinv_seq.sv
module rinv_seq #(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int MAX_INV     = 64,
    parameter int MULTI_MAJOR = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [31:0]       hw_version,
    output logic              busy,
    output logic              done,
    output logic              flush_valid,
    input  logic              flush_ready,
    output logic [ADDR_W-1:0] flush_data
);

    localparam int CNT_W = $clog2(MAX_INV + 1);

    logic [CNT_W-1:0] calc_cnt;
    logic             load;
    logic             step;

    rinv_count_calc #(
        .SIZE_W     (SIZE_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .MAX_INV    (MAX_INV),
        .CNT_W      (CNT_W),
        .MULTI_MAJOR(MULTI_MAJOR)
    ) count_i (
        .req_size  (req_size),
        .hw_version(hw_version),
        .inv_count (calc_cnt)
    );

    rinv_ctrl #(
        .CNT_W(CNT_W)
    ) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .load_cnt   (calc_cnt),
        .flush_ready(flush_ready),
        .busy       (busy),
        .done       (done),
        .flush_valid(flush_valid),
        .load       (load),
        .step       (step)
    );

    rinv_addr_step #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) addr_i (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (req_addr),
        .step      (step),
        .flush_data(flush_data)
    );

    // R6: every offered word is page aligned with the valid bit set
    a_r6_word_format: assert property (@(posedge clk) disable iff (rst)
        flush_valid |-> (flush_data[0] && flush_data[PAGE_SHIFT-1:1] == '0));

    // R8: busy and done never overlap
    a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

endmodule

// File: tb/rinv_seq_tb_top.sv
module rinv_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_addr;
    logic [31:0] req_size;
    logic [31:0] hw_version;
    logic        busy, done, flush_valid, flush_ready;
    logic [31:0] flush_data;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk; // 125 MHz

    rinv_seq dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .hw_version(hw_version), .busy(busy), .done(done),
        .flush_valid(flush_valid), .flush_ready(flush_ready), .flush_data(flush_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Issue one request and follow its series to done.
    task automatic run_case(input string tag, input logic [31:0] addr,
                            input logic [31:0] size, input logic [3:0] major,
                            input bit stall, input bit poke, input int exp_n);
        int          n = 0;
        int          cyc = 0;
        bit          addr_ok = 1'b1;
        logic [31:0] exp_word;
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = addr;
        req_size    = size;
        hw_version  = {major, 28'h0012345};
        flush_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R8 busy after accept"}, 32'(busy), 32'd1);
        while (!done && cyc < 1000) begin
            if (poke && cyc == 1) begin
                req_valid = 1'b1;               // R9: must be ignored
                req_addr  = 32'hF000_0000;
                req_size  = 32'h0010_0000;
            end else begin
                req_valid = 1'b0;
            end
            flush_ready = stall ? cyc[0] : 1'b1;
            if (flush_valid && flush_ready) begin
                exp_word = ((addr & 32'hFFFF_F000) + 32'(n) * 32'h1000) | 32'h1;
                if (flush_data !== exp_word) begin
                    if (addr_ok)
                        check({tag, " R6 R7 flush word"}, flush_data, exp_word);
                    addr_ok = 1'b0;
                end
                n++;
            end
            if (!busy || !flush_valid) begin
                check({tag, " R8 busy/valid during series"}, {busy, flush_valid}, 2'b11);
                cyc = 1000;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        if (addr_ok) check({tag, " R6 R7 flush words"}, 32'd1, 32'd1);
        check({tag, " R8 done seen"}, 32'(done), 32'd1);
        check({tag, " R8 busy low at done"}, 32'(busy), 32'd0);
        check({tag, " flush count"}, 32'(n), 32'(exp_n));
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 32'(done), 32'd0);
        check({tag, " R9 no queued request"}, 32'(busy), 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_size = '0;
        hw_version = '0; flush_ready = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset done", 32'(done), 32'd0);
        check("R1 reset valid", 32'(flush_valid), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 post-reset idle", {busy, done, flush_valid}, 3'b000);
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        run_case("R2 other rev 1MB", 32'h1234_5678, 32'h0010_0000, 4'h1, 0, 0, 1);
        run_case("R2 rev3 64KB",     32'h0000_3000, 32'h0001_0000, 4'h3, 0, 0, 1);
        run_case("R3 rev2 4KB",      32'h4000_0ABC, 32'h0000_1000, 4'h2, 0, 0, 1);
        run_case("R3 rev2 64KB",     32'h0801_0000, 32'h0001_0000, 4'h2, 0, 0, 16);
        run_case("R3 rev2 12KB+",    32'h0000_5FFF, 32'h0000_3800, 4'h2, 0, 0, 3);
        run_case("R4 rev2 1MB",      32'h2010_0000, 32'h0010_0000, 4'h2, 0, 0, 64);
        run_case("R4 rev2 2MB",      32'h3000_0000, 32'h0020_0000, 4'h2, 0, 0, 64);
        run_case("R5 rev2 small",    32'h0000_7123, 32'h0000_0200, 4'h2, 0, 0, 1);
        run_case("R5 rev2 zero",     32'h0000_9000, 32'h0000_0000, 4'h2, 0, 0, 1);
        run_case("R10 stall 64KB",   32'h5555_5555, 32'h0001_0000, 4'h2, 1, 0, 16);
        run_case("R9 poke busy",     32'h0600_0000, 32'h0000_8000, 4'h2, 0, 1, 8);
        run_case("R9 R10 poke stall",32'h0700_0000, 32'h0000_4000, 4'h2, 1, 1, 4);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule